// File: doc/BRIEF.md
# Sixteen-Channel Prioritised Interrupt Controller

The block collects sixteen single-cycle interrupt strobes and keeps four bits of state for each channel: enable, pending, mask and in-service. Each of these is held in two 8-bit halves. The upper half covers channels 15..8 and the lower half covers channels 7..0. A strobe on an enabled channel latches a pending bit. Software can poll the pending bits through a small register port. It can also let the block raise an active-low request and answer an acknowledge strobe with a vector that names the winning channel.

Several such blocks can share one request line in a daisy chain. An active-low chain input tells the block that no device above it is asking for service. The block then drives an active-low chain output for the devices below it. When the in-service mode bit is set, acknowledging a channel marks that channel as in service. Channels of the same or lower priority then stay silent until software clears the in-service bit.

Top module: `irq_vec16`

## Requirements
- R1: After reset, every register reads 0 and `irq_n` is 1. Every channel is disabled, masked and neither pending nor in service.
- R2: A strobe sets a channel's pending bit only when that channel's enable bit is 1. Writing 0 to an enable bit also clears the matching pending bit.
- R3: `irq_n` is 0 exactly when some pending channel has its mask bit at 1, is eligible under R8, and `ack` is low. Mask bit 1 means the channel may request.
- R4: The mask has no effect on the pending bits read back, so masked channels can be polled.
- R5: Channel 15 has the highest priority and channel 0 the lowest. The vector is {vector register bits 7:4, 4-bit channel number}.
- R6: An `ack` strobe is answered only while `chain_in_n` is 0 and a request exists. In that case, `vec_valid` is 1 with `vec` for exactly one cycle, starting the cycle after `ack`, and the answered channel's pending bit clears.
- R7: `chain_out_n` is 0 only while `chain_in_n` is 0 and the block has no request.
- R8: When vector register bit 3 is 1, an answered acknowledge sets that channel's in-service bit. In that mode a channel is eligible only if no in-service bit is set at its own position or above.
- R9: Writing a 0 to a pending or in-service bit clears that bit. Writing a 1 leaves it unchanged.
- R10: A cycle with `reg_sel` and `ack` both 1 has no effect on any register and produces no vector.
- R11: The register addresses are: 0 enable upper, 1 enable lower, 2 pending upper, 3 pending lower, 4 in-service upper, 5 in-service lower, 6 mask upper, 7 mask lower, 8 vector register. In each half, bit k maps to channel 8+k in the upper half and to channel k in the lower half. The vector register keeps bits 7:3, and its bits 2:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stb | input | 16 | One-cycle interrupt strobes, bit i is channel i |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| ack | input | 1 | Acknowledge strobe |
| chain_in_n | input | 1 | Low: no higher device requesting |
| chain_out_n | output | 1 | Low: neither this nor a higher device requesting |
| irq_n | output | 1 | Active-low interrupt request |
| vec_valid | output | 1 | Vector present |
| vec | output | 8 | Interrupt vector |

## Verification
Channel 15 and channel 0 are made pending together and then acknowledged twice. This shows that the vector order follows priority and not arrival order. Three more patterns each separate a distinct gate on the request:
- a pending but masked channel;
- a strobe on a disabled channel;
- an acknowledge with `chain_in_n` high.

The in-service sequence confirms two things. A lower channel stays blocked while a higher one is in service, and a higher channel still gets through. A clash of register select and acknowledge is driven, and the bench confirms that neither a write nor a vector results.

// File: rtl/irq_vec16.sv
module irq_vec16 #(
  parameter int HALF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*HALF-1:0] src_stb,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [HALF-1:0]   wdata,
  output logic [HALF-1:0]   rdata,
  input  logic              ack,
  input  logic              chain_in_n,
  output logic              chain_out_n,
  output logic              irq_n,
  output logic              vec_valid,
  output logic [7:0]        vec
);
  localparam int NCH = 2 * HALF;

  logic [NCH-1:0] en, pend, ins, mask;
  logic [4:0]     vreg;
  logic [NCH-1:0] active, elig, ack_bit, en_n, pend_n, ins_n;
  logic [3:0]     win;
  logic           req, wr, rd, take;

  assign wr     = reg_sel & reg_wr & ~ack;
  assign rd     = reg_sel & ~reg_wr & ~ack;
  assign active = pend & mask;

  always_comb begin
    logic blk;
    blk  = 1'b0;
    elig = '0;
    win  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      blk     = blk | (vreg[0] & ins[i]);
      elig[i] = active[i] & ~blk;
    end
    for (int i = 0; i < NCH; i++)
      if (elig[i]) win = 4'(i);
  end

  assign req         = |elig;
  assign irq_n       = ~(req & ~ack);
  assign chain_out_n = ~(~chain_in_n & ~req);
  assign take        = ack & ~reg_sel & ~chain_in_n & req;
  assign ack_bit     = take ? (NCH'(1) << win) : '0;

  function automatic logic [NCH-1:0] put(input logic [NCH-1:0] cur,
                                         input logic hi, input logic [HALF-1:0] d);
    return hi ? {d, cur[HALF-1:0]} : {cur[NCH-1:HALF], d};
  endfunction

  function automatic logic [NCH-1:0] keep(input logic [NCH-1:0] cur,
                                          input logic hi, input logic [HALF-1:0] d);
    return hi ? {cur[NCH-1:HALF] & d, cur[HALF-1:0]} : {cur[NCH-1:HALF], cur[HALF-1:0] & d};
  endfunction

  always_comb begin
    en_n   = en;
    pend_n = pend;
    ins_n  = ins;
    if (wr && reg_addr[3:1] == 3'd0) en_n   = put(en, ~reg_addr[0], wdata);
    if (wr && reg_addr[3:1] == 3'd1) pend_n = keep(pend, ~reg_addr[0], wdata);
    if (wr && reg_addr[3:1] == 3'd2) ins_n  = keep(ins, ~reg_addr[0], wdata);
    pend_n = ((pend_n & ~ack_bit) | src_stb) & en_n;
    if (vreg[0]) ins_n = ins_n | ack_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= '0;
      pend      <= '0;
      ins       <= '0;
      mask      <= '0;
      vreg      <= '0;
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      en        <= en_n;
      pend      <= pend_n;
      ins       <= ins_n;
      if (wr && reg_addr[3:1] == 3'd3) mask <= put(mask, ~reg_addr[0], wdata);
      if (wr && reg_addr == 4'd8) vreg <= wdata[7:3];
      vec_valid <= take;
      if (take) vec <= {vreg[4:1], win};
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (reg_addr)
        4'd0: rdata = en[NCH-1:HALF];
        4'd1: rdata = en[HALF-1:0];
        4'd2: rdata = pend[NCH-1:HALF];
        4'd3: rdata = pend[HALF-1:0];
        4'd4: rdata = ins[NCH-1:HALF];
        4'd5: rdata = ins[HALF-1:0];
        4'd6: rdata = mask[NCH-1:HALF];
        4'd7: rdata = mask[HALF-1:0];
        4'd8: rdata = {vreg, 3'b000};
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec16_chk.sv
module irq_vec16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        ack,
  input logic        chain_in_n,
  input logic        chain_out_n,
  input logic        irq_n,
  input logic        vec_valid,
  input logic [15:0] en,
  input logic [15:0] pend,
  input logic [15:0] mask,
  input logic [4:0]  vreg
);
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en) == 16'h0); // R2
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((pend & mask) != 16'h0 && !ack)); // R3
  AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack && !reg_sel && !chain_in_n)); // R6
  AST_CHAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_out_n |-> !chain_in_n); // R7
  AST_CLASH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && ack) |=> (en == $past(en) && mask == $past(mask) && vreg == $past(vreg) && !vec_valid)); // R10
endmodule

bind irq_vec16 irq_vec16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .ack(ack),
  .chain_in_n(chain_in_n), .chain_out_n(chain_out_n), .irq_n(irq_n),
  .vec_valid(vec_valid), .en(en), .pend(pend), .mask(mask), .vreg(vreg)
);

// File: tb/test_irq_vec16.sv
module test_irq_vec16;
  logic        clk = 0, rst_n = 0;
  logic [15:0] src_stb = '0;
  logic        reg_sel = 0, reg_wr = 0, ack = 0, chain_in_n = 0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  wdata = '0, rdata, vec;
  logic        chain_out_n, irq_n, vec_valid;
  int          checks = 0, fails = 0;
  logic [7:0]  sbq[$];
  logic        done = 0;

  irq_vec16 i_irq_vec16 (.clk, .rst_n, .src_stb, .reg_sel, .reg_wr, .reg_addr,
    .wdata, .rdata, .ack, .chain_in_n, .chain_out_n, .irq_n, .vec_valid, .vec);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (vec_valid) begin
      if (sbq.size() == 0) chk("R6 unexpected vector", vec, 8'hxx);
      else chk("R5 vector", vec, sbq.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; wdata = d;
    @(posedge clk); #1 reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 chk(req, rdata, exp);
    @(posedge clk); #1 reg_sel = 0;
  endtask

  task automatic stb(input int ch);
    @(negedge clk); src_stb = 16'(1) << ch;
    @(posedge clk); #1 src_stb = '0;
  endtask

  task automatic do_ack(input logic expect_vec, input logic [7:0] v);
    @(negedge clk); ack = 1;
    if (expect_vec) sbq.push_back(v);
    @(posedge clk); #1 ack = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pins(input string req, input logic exp_irq, input logic exp_co);
    @(negedge clk); #1;
    chk(req, {7'd0, irq_n}, {7'd0, exp_irq});
    chk(req, {7'd0, chain_out_n}, {7'd0, exp_co});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 0; a < 9; a++) rdchk("R1 reset reg", 4'(a), 8'h00);
    pins("R1 R7 reset pins", 1'b1, 1'b0);

    wr(4'd8, 8'h47);
    rdchk("R11 vector reg", 4'd8, 8'h40);
    wr(4'd1, 8'h01);
    stb(1);
    rdchk("R2 disabled strobe", 4'd3, 8'h00);
    stb(0);
    rdchk("R2 enabled strobe", 4'd3, 8'h01);
    pins("R3 masked no irq", 1'b1, 1'b0);
    rdchk("R4 masked still polled", 4'd3, 8'h01);
    wr(4'd7, 8'h01);
    pins("R3 R7 unmasked irq", 1'b0, 1'b1);

    wr(4'd0, 8'h80); wr(4'd6, 8'h80);
    stb(15);
    rdchk("R11 pending upper", 4'd2, 8'h80);
    do_ack(1'b1, 8'h4F);
    pins("R3 ch0 remains", 1'b0, 1'b1);
    do_ack(1'b1, 8'h40);
    pins("R6 pending consumed", 1'b1, 1'b0);

    stb(0);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = 4'd1; wdata = 8'h00; ack = 1;
    @(posedge clk); #1 reg_sel = 0; reg_wr = 0; ack = 0;
    rdchk("R10 clash no write", 4'd1, 8'h01);
    rdchk("R10 clash no ack", 4'd3, 8'h01);

    chain_in_n = 1;
    do_ack(1'b0, 8'h00);
    pins("R6 R7 chain blocked", 1'b0, 1'b1);
    rdchk("R6 no ack when chain high", 4'd3, 8'h01);
    chain_in_n = 0;

    wr(4'd3, 8'hFF);
    rdchk("R9 write one keeps", 4'd3, 8'h01);
    wr(4'd3, 8'hFE);
    rdchk("R9 write zero clears", 4'd3, 8'h00);
    pins("R9 irq drops", 1'b1, 1'b0);

    stb(0);
    wr(4'd1, 8'h00);
    rdchk("R2 disable clears pending", 4'd3, 8'h00);

    wr(4'd8, 8'h48);
    wr(4'd1, 8'h0F); wr(4'd7, 8'h0F);
    stb(2);
    do_ack(1'b1, 8'h42);
    rdchk("R8 in-service set", 4'd5, 8'h04);
    rdchk("R8 pending cleared", 4'd3, 8'h00);
    stb(1);
    pins("R8 lower held off", 1'b1, 1'b0);
    stb(15);
    pins("R8 higher passes", 1'b0, 1'b1);
    do_ack(1'b1, 8'h4F);
    rdchk("R8 upper in-service", 4'd4, 8'h80);
    wr(4'd4, 8'h00);
    pins("R8 still blocked by ch2", 1'b1, 1'b0);
    wr(4'd5, 8'hFB);
    rdchk("R9 in-service cleared", 4'd5, 8'h00);
    pins("R8 released", 1'b0, 1'b1);
    do_ack(1'b1, 8'h41);

    repeat (3) @(negedge clk);
    done = 1;
    chk("R6 all vectors seen", 8'(sbq.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule